// File: doc/BRIEF.md
# Looping Pattern Generator

This block keeps a pattern memory of 1023 words, each 8 bits wide. In load mode, software fills the memory one word at a time. It writes a word register and then strobes a step register, which stores that word and moves a load pointer to the next address.

In play mode the block steps through an address window from a first address to a last address. It produces one word for each pulse of an external sample enable, and it repeats the window a programmed number of times. Every output word passes through a per-bit enable mask. The window starts on one of three selectable events: a software trigger, a rising scope trigger, or a rising scope arm signal.

Configuration arrives as single-cycle byte writes on an address/data/strobe port, such as from an upstream command decoder. The sample enable stands in for a separate rate generator.

Top module: `pgen_top`

## Requirements
- R1: After reset, `busy` is 0, `pat_out` is 0 and every configuration register holds 0.
- R2: Load mode is active while bit 0 of the control register (offset 0) is 1. In load mode, a write to the step register (offset 3) with data bit 0 = 1, while its stored bit 0 is 0, stores the word register (offset 2) at the load pointer and advances the pointer by one.
- R3: A step write with bit 0 = 0, or a repeated write of 1, leaves the pointer unchanged. The pointer stops at address 1022, so further steps overwrite that address. While load mode is off, the pointer is held at 0.
- R4: Control bits [2:1] select the start event. 11 starts on a manual register write (offset 1) of bit 0 = 1 over a stored 0. 10 starts on a rising `scope_trig`. 01 starts on a rising `scope_arm`. 00 selects no event. A start is taken only while the block is idle and load mode is off.
- R5: At a start, `busy` rises and the held output word clears to 0. Each later `sample_en` cycle then outputs the word at the current address and advances the address, from the first address to the last address.
- R6: The loop register (offset 8) sets the pass count N > 0. `busy` falls on the `sample_en` cycle that outputs the last word of pass N, and that word stays on `pat_out`.
- R7: A loop count of 0 repeats passes without end. During playback, selecting source 00 or entering load mode drops `busy` one cycle after the control register is written.
- R8: `pat_out` equals the held word ANDed with the mask register (offset 9), and a mask write takes effect at once.
- R9: A start that coincides with `sample_en` outputs no word in that cycle. A start event that arrives while the block is busy is ignored.
- R10: The first address is {offset 5 bits [1:0], offset 4}. The last address is {offset 7 bits [1:0], offset 6} + 2. Both are limited to 1022.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| sample_en | input | 1 | One output word per high cycle during playback |
| scope_trig | input | 1 | Scope trigger, rising edge starts source 10 |
| scope_arm | input | 1 | Scope arm, rising edge starts source 01 |
| pat_out | output | 8 | Masked pattern word |
| busy | output | 1 | High during playback |

## Verification
The two functions that can land in one cycle are the start event and a sample enable, as well as a second start event and an ongoing playback step. The bench raises `scope_trig` and `sample_en` on the same edge and expects `busy` high with an output of 0. It then sends a fresh trigger mid-window and expects the next sample to continue from the next address rather than restarting. A behavioural reference model compares `busy` and `pat_out` on every clock, so any wrong priority between these events shows up as a word or busy mismatch.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
   // register offsets on the byte write port
   typedef enum logic [3:0] {
      RG_CTRL     = 4'd0,
      RG_MANUAL   = 4'd1,
      RG_WORD     = 4'd2,
      RG_STEP     = 4'd3,
      RG_FIRST_LO = 4'd4,
      RG_FIRST_HI = 4'd5,
      RG_LAST_LO  = 4'd6,
      RG_LAST_HI  = 4'd7,
      RG_LOOPS    = 4'd8,
      RG_MASK     = 4'd9
   } reg_sel_e;

   typedef enum logic [1:0] {
      SRC_OFF    = 2'b00,
      SRC_ARM    = 2'b01,
      SRC_TRIG   = 2'b10,
      SRC_MANUAL = 2'b11
   } start_src_e;

   // programmed last address lies this far below the real last address
   localparam int unsigned END_BIAS = 2;
endpackage

// File: rtl/pgen_regs.sv
module pgen_regs
   import pgen_pkg::*;
#(
   parameter int unsigned AW = 10,
   parameter int unsigned DW = 8,
   parameter int unsigned LW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [3:0]    addr,
   input  logic [7:0]    wdata,
   output logic          load_mode,
   output start_src_e    src,
   output logic [AW-1:0] first_raw,
   output logic [AW-1:0] last_raw,
   output logic [LW-1:0] loops,
   output logic [DW-1:0] mask,
   output logic [DW-1:0] word,
   output logic          man_fire,
   output logic          step_fire
);
   localparam int unsigned HB = AW - 8;

   logic [2:0]    ctrl_q;
   logic          man_q;
   logic          step_q;
   logic [DW-1:0] word_q;
   logic [DW-1:0] mask_q;
   logic [LW-1:0] loops_q;
   logic [7:0]    first_lo_q;
   logic [7:0]    last_lo_q;
   logic [HB-1:0] first_hi_q;
   logic [HB-1:0] last_hi_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl_q     <= '0;
         man_q      <= 1'b0;
         step_q     <= 1'b0;
         word_q     <= '0;
         mask_q     <= '0;
         loops_q    <= '0;
         first_lo_q <= '0;
         last_lo_q  <= '0;
         first_hi_q <= '0;
         last_hi_q  <= '0;
      end else if (we) begin
         case (addr)
            RG_CTRL:     ctrl_q     <= wdata[2:0];
            RG_MANUAL:   man_q      <= wdata[0];
            RG_WORD:     word_q     <= wdata[DW-1:0];
            RG_STEP:     step_q     <= wdata[0];
            RG_FIRST_LO: first_lo_q <= wdata;
            RG_FIRST_HI: first_hi_q <= wdata[HB-1:0];
            RG_LAST_LO:  last_lo_q  <= wdata;
            RG_LAST_HI:  last_hi_q  <= wdata[HB-1:0];
            RG_LOOPS:    loops_q    <= wdata[LW-1:0];
            RG_MASK:     mask_q     <= wdata[DW-1:0];
            default: ;
         endcase
      end
   end

   // strobes act only on a 0 -> 1 change of the stored bit
   assign man_fire  = we && (addr == RG_MANUAL) && wdata[0] && !man_q;
   assign step_fire = we && (addr == RG_STEP)   && wdata[0] && !step_q;

   assign load_mode = ctrl_q[0];
   assign src       = start_src_e'(ctrl_q[2:1]);
   assign first_raw = {first_hi_q, first_lo_q};
   assign last_raw  = {last_hi_q, last_lo_q};
   assign loops     = loops_q;
   assign mask      = mask_q;
   assign word      = word_q;
endmodule

// File: rtl/pgen_loader.sv
module pgen_loader #(
   parameter int unsigned AW    = 10,
   parameter int unsigned DEPTH = 1023
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_mode,
   input  logic          step_fire,
   output logic [AW-1:0] ptr,
   output logic          mem_we
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   logic [AW-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (rst || !load_mode) begin
         ptr_q <= '0;
      end else if (step_fire && (ptr_q != TOP)) begin
         ptr_q <= ptr_q + AW'(1);
      end
   end

   assign ptr    = ptr_q;
   assign mem_we = load_mode && step_fire;
endmodule

// File: rtl/pgen_store.sv
module pgen_store #(
   parameter int unsigned AW    = 10,
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 1023
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/pgen_player.sv
module pgen_player
   import pgen_pkg::*;
#(
   parameter int unsigned AW    = 10,
   parameter int unsigned DW    = 8,
   parameter int unsigned LW    = 8,
   parameter int unsigned DEPTH = 1023
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load_mode,
   input  start_src_e    src,
   input  logic          man_fire,
   input  logic          scope_trig,
   input  logic          scope_arm,
   input  logic          sample_en,
   input  logic [AW-1:0] first_raw,
   input  logic [AW-1:0] last_raw,
   input  logic [LW-1:0] loops,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic [DW-1:0] raw_word,
   output logic          busy
);
   localparam logic [AW:0] LIM = (AW + 1)'(DEPTH - 1);

   logic          busy_q;
   logic [AW-1:0] addr_q;
   logic [LW-1:0] left_q;
   logic [DW-1:0] raw_q;
   logic          trig_q;
   logic          arm_q;

   // event per source code; code 0 never fires
   logic [3:0]    ev;
   logic          src_hit;
   logic          start_go;
   logic          halt;
   logic [AW:0]   last_sum;
   logic [AW-1:0] first_eff;
   logic [AW-1:0] last_eff;
   logic          at_last;

   assign ev[SRC_OFF]    = 1'b0;
   assign ev[SRC_ARM]    = scope_arm && !arm_q;
   assign ev[SRC_TRIG]   = scope_trig && !trig_q;
   assign ev[SRC_MANUAL] = man_fire;

   assign src_hit  = ev[src];
   assign start_go = !busy_q && !load_mode && src_hit;
   assign halt     = load_mode || (src == SRC_OFF);

   assign first_eff = ({1'b0, first_raw} > LIM) ? LIM[AW-1:0] : first_raw;
   assign last_sum  = {1'b0, last_raw} + (AW + 1)'(END_BIAS);
   assign last_eff  = (last_sum > LIM) ? LIM[AW-1:0] : last_sum[AW-1:0];
   assign at_last   = addr_q >= last_eff;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         addr_q <= '0;
         left_q <= '0;
         raw_q  <= '0;
         trig_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         trig_q <= scope_trig;
         arm_q  <= scope_arm;
         if (busy_q && halt) begin
            busy_q <= 1'b0;
         end else if (start_go) begin
            busy_q <= 1'b1;
            addr_q <= first_eff;
            left_q <= loops;
            raw_q  <= '0;
         end else if (busy_q && sample_en) begin
            raw_q <= rd_data;
            if (at_last) begin
               if (left_q == LW'(1)) begin
                  busy_q <= 1'b0;
               end else begin
                  if (left_q != '0) left_q <= left_q - LW'(1);
                  addr_q <= first_eff;
               end
            end else begin
               addr_q <= addr_q + AW'(1);
            end
         end
      end
   end

   assign rd_addr  = addr_q;
   assign raw_word = raw_q;
   assign busy     = busy_q;
endmodule

// File: rtl/pgen_top.sv
module pgen_top
   import pgen_pkg::*;
#(
   parameter int unsigned AW      = 10,
   parameter int unsigned DW      = 8,
   parameter int unsigned LW      = 8,
   parameter int unsigned DEPTH   = 1023,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          reg_we,
   input  logic [3:0]    reg_addr,
   input  logic [7:0]    reg_wdata,
   input  logic          sample_en,
   input  logic          scope_trig,
   input  logic          scope_arm,
   output logic [DW-1:0] pat_out,
   output logic          busy
);
   if (AW < 9 || AW > 16) begin : g_bad_aw
      $error("pgen_top: AW must lie in 9..16");
   end
   if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("pgen_top: DEPTH must lie in 2..2**AW");
   end
   if (DW < 1 || DW > 8) begin : g_bad_dw
      $error("pgen_top: DW must lie in 1..8");
   end
   if (LW < 1 || LW > 8) begin : g_bad_lw
      $error("pgen_top: LW must lie in 1..8");
   end

   logic          load_mode;
   start_src_e    src_sel;
   logic [AW-1:0] first_raw;
   logic [AW-1:0] last_raw;
   logic [LW-1:0] loops_q;
   logic [DW-1:0] mask_q;
   logic [DW-1:0] word_q;
   logic          man_fire;
   logic          step_fire;
   logic [AW-1:0] load_ptr;
   logic          mem_we;
   logic [AW-1:0] play_addr;
   logic [DW-1:0] rd_data;
   logic [DW-1:0] raw_word;

   pgen_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
      .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .load_mode(load_mode), .src(src_sel), .first_raw(first_raw),
      .last_raw(last_raw), .loops(loops_q), .mask(mask_q), .word(word_q),
      .man_fire(man_fire), .step_fire(step_fire)
   );

   pgen_loader #(.AW(AW), .DEPTH(DEPTH)) u_loader (
      .clk(clk), .rst(rst), .load_mode(load_mode), .step_fire(step_fire),
      .ptr(load_ptr), .mem_we(mem_we)
   );

   pgen_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we(mem_we), .waddr(load_ptr), .wdata(word_q),
      .raddr(play_addr), .rdata(rd_data)
   );

   pgen_player #(.AW(AW), .DW(DW), .LW(LW), .DEPTH(DEPTH)) u_player (
      .clk(clk), .rst(rst), .load_mode(load_mode), .src(src_sel),
      .man_fire(man_fire), .scope_trig(scope_trig), .scope_arm(scope_arm),
      .sample_en(sample_en), .first_raw(first_raw), .last_raw(last_raw),
      .loops(loops_q), .rd_data(rd_data), .rd_addr(play_addr),
      .raw_word(raw_word), .busy(busy)
   );

   if (OUT_REG) begin : g_out_reg
      logic [DW-1:0] pat_q;
      always_ff @(posedge clk) begin
         if (rst) pat_q <= '0;
         else     pat_q <= raw_word & mask_q;
      end
      assign pat_out = pat_q;
   end else begin : g_out_comb
      assign pat_out = raw_word & mask_q;
   end
endmodule

// File: rtl/pgen_check.sv
module pgen_check #(
   parameter int unsigned AW      = 10,
   parameter int unsigned DW      = 8,
   parameter int unsigned DEPTH   = 1023,
   parameter bit          OUT_REG = 1'b0
) (
   input logic          clk,
   input logic          rst,
   input logic          busy,
   input logic          load_mode,
   input logic [1:0]    src,
   input logic          step_fire,
   input logic [AW-1:0] ptr,
   input logic [AW-1:0] play_addr,
   input logic [DW-1:0] raw_word,
   input logic [DW-1:0] mask,
   input logic [DW-1:0] pat_out
);
   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   assert_step_moves_R2: assert property (@(posedge clk) disable iff (rst)
      (load_mode && step_fire && ptr != TOP) |=> (ptr == $past(ptr) + AW'(1)));

   assert_ptr_holds_R3: assert property (@(posedge clk) disable iff (rst)
      (load_mode && !step_fire) |=> $stable(ptr));

   assert_ptr_cap_R3: assert property (@(posedge clk) disable iff (rst)
      ptr <= TOP);

   assert_no_start_off_R4: assert property (@(posedge clk) disable iff (rst)
      (!busy && src == 2'b00) |=> !busy);

   assert_no_start_load_R4: assert property (@(posedge clk) disable iff (rst)
      (!busy && load_mode) |=> !busy);

   assert_addr_range_R5: assert property (@(posedge clk) disable iff (rst)
      busy |-> play_addr <= TOP);

   assert_start_clears_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> raw_word == '0);

   assert_halt_R7: assert property (@(posedge clk) disable iff (rst)
      (busy && (src == 2'b00 || load_mode)) |=> !busy);

   if (!OUT_REG) begin : g_mask_chk
      assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
         (pat_out & ~mask) == '0);
   end
endmodule

bind pgen_top pgen_check #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .OUT_REG(OUT_REG)) u_check (
   .clk(clk), .rst(rst), .busy(busy), .load_mode(load_mode), .src(src_sel),
   .step_fire(step_fire), .ptr(load_ptr), .play_addr(play_addr),
   .raw_word(raw_word), .mask(mask_q), .pat_out(pat_out)
);

// File: tb/sim_pgen_top.sv
module sim_pgen_top;
   localparam int DEPTH = 1023;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_we = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       sample_en = 1'b0;
   logic       scope_trig = 1'b0;
   logic       scope_arm = 1'b0;
   logic [7:0] pat_out;
   logic       busy;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pgen_top u0 (
      .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .sample_en(sample_en), .scope_trig(scope_trig),
      .scope_arm(scope_arm), .pat_out(pat_out), .busy(busy)
   );

   // ---------------- behavioural reference model ----------------
   int m_mem [DEPTH];
   int m_cfg, m_man, m_word, m_step, m_flo, m_fhi, m_llo, m_lhi, m_loops, m_mask;
   int m_wp, m_busy, m_addr, m_left, m_raw, m_trq, m_arq;
   int t_src, t_lm, t_first, t_last, t_start, t_fman, t_fstep;

   function automatic int lim(input int v);
      return (v > DEPTH - 1) ? DEPTH - 1 : v;
   endfunction

   function automatic int wv(input int i);
      return (i * 7 + 3) & 255;
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cfg = 0; m_man = 0; m_word = 0; m_step = 0; m_flo = 0; m_fhi = 0;
         m_llo = 0; m_lhi = 0; m_loops = 0; m_mask = 0; m_wp = 0; m_busy = 0;
         m_addr = 0; m_left = 0; m_raw = 0; m_trq = 0; m_arq = 0;
      end else begin
         t_src   = (m_cfg >> 1) & 3;
         t_lm    = m_cfg & 1;
         t_fman  = (reg_we && reg_addr == 1 && reg_wdata[0] && m_man == 0) ? 1 : 0;
         t_fstep = (reg_we && reg_addr == 3 && reg_wdata[0] && m_step == 0) ? 1 : 0;
         t_first = lim(((m_fhi & 3) << 8) | m_flo);
         t_last  = lim((((m_lhi & 3) << 8) | m_llo) + 2);
         t_start = (m_busy == 0 && t_lm == 0 &&
                    ((t_src == 3 && t_fman == 1) ||
                     (t_src == 2 && scope_trig && m_trq == 0) ||
                     (t_src == 1 && scope_arm && m_arq == 0))) ? 1 : 0;
         if (m_busy == 1 && (t_src == 0 || t_lm == 1)) begin
            m_busy = 0;
         end else if (t_start == 1) begin
            m_busy = 1; m_addr = t_first; m_left = m_loops; m_raw = 0;
         end else if (m_busy == 1 && sample_en) begin
            m_raw = m_mem[m_addr];
            if (m_addr >= t_last) begin
               if (m_left == 1) m_busy = 0;
               else begin
                  if (m_left != 0) m_left = m_left - 1;
                  m_addr = t_first;
               end
            end else m_addr = m_addr + 1;
         end
         if (t_lm == 0) m_wp = 0;
         else if (t_fstep == 1) begin
            m_mem[m_wp] = m_word;
            if (m_wp < DEPTH - 1) m_wp = m_wp + 1;
         end
         m_trq = scope_trig ? 1 : 0;
         m_arq = scope_arm ? 1 : 0;
         if (reg_we) begin
            case (reg_addr)
               4'd0: m_cfg   = reg_wdata & 7;
               4'd1: m_man   = reg_wdata & 1;
               4'd2: m_word  = reg_wdata;
               4'd3: m_step  = reg_wdata & 1;
               4'd4: m_flo   = reg_wdata;
               4'd5: m_fhi   = reg_wdata & 3;
               4'd6: m_llo   = reg_wdata;
               4'd7: m_lhi   = reg_wdata & 3;
               4'd8: m_loops = reg_wdata;
               4'd9: m_mask  = reg_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic check(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   // every-clock comparison against the model (R5 playback, R6/R7 busy, R8 mask)
   always @(negedge clk) begin
      if (!rst) begin
         check("R6 busy vs model", int'(busy), m_busy);
         check("R8 pat_out vs model", int'(pat_out), m_raw & m_mask);
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic sen;
      @(negedge clk); sample_en = 1'b1;
      @(negedge clk); sample_en = 1'b0;
   endtask

   task automatic trig_pulse;
      @(negedge clk); scope_trig = 1'b1;
      @(negedge clk); scope_trig = 1'b0;
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R5 watchdog: got hung expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check("R1 busy after reset", int'(busy), 0);
      check("R1 pat_out after reset", int'(pat_out), 0);

      // R2/R3: full load, doubled step at index 5, two extra saturating steps
      wr(0, 1);
      for (int i = 0; i < DEPTH; i++) begin
         wr(2, wv(i)); wr(3, 1);
         if (i == 5) wr(3, 1);
         wr(3, 0);
      end
      wr(2, 'hA5); wr(3, 1); wr(3, 0);
      wr(2, 'h5A); wr(3, 1); wr(3, 0);
      wr(0, 0);

      // window 2..7 (last reg 5), two passes, manual source
      wr(4, 2); wr(5, 0); wr(6, 5); wr(7, 0); wr(8, 2); wr(9, 'hFF);
      wr(0, 6); wr(1, 1); wr(1, 0);
      check("R4 manual start busy", int'(busy), 1);
      check("R5 output cleared at start", int'(pat_out), 0);
      for (int p = 0; p < 2; p++) begin
         for (int k = 2; k <= 7; k++) begin
            sen();
            check("R5 playback word (R3 double step)", int'(pat_out), wv(k));
            if (!(p == 1 && k == 7)) check("R6 busy mid run", int'(busy), 1);
         end
      end
      check("R6 busy after last pass", int'(busy), 0);
      wr(9, 'h0F);
      check("R8 mask applied", int'(pat_out), wv(7) & 'h0F);
      wr(9, 'hFF);
      check("R6 last word held", int'(pat_out), wv(7));

      // R9: start together with sample_en, then trigger while busy
      wr(0, 4);
      @(negedge clk); scope_trig = 1'b1; sample_en = 1'b1;
      @(negedge clk); scope_trig = 1'b0; sample_en = 1'b0;
      check("R9 start with sample busy", int'(busy), 1);
      check("R9 start with sample output", int'(pat_out), 0);
      sen();
      check("R9 first word after collision", int'(pat_out), wv(2));
      trig_pulse();
      sen();
      check("R9 retrigger ignored", int'(pat_out), wv(3));
      wr(0, 0);
      @(negedge clk);
      check("R7 abort by source off", int'(busy), 0);

      // R4: arm source, off source, load mode blocking
      wr(0, 2);
      @(negedge clk); scope_arm = 1'b1;
      @(negedge clk); scope_arm = 1'b0;
      check("R4 arm start", int'(busy), 1);
      wr(0, 0);
      @(negedge clk);
      trig_pulse();
      check("R4 source off no start", int'(busy), 0);
      wr(0, 5);
      trig_pulse();
      check("R4 load mode blocks start", int'(busy), 0);

      // R3: pointer back at 0 after leaving load mode
      wr(2, 'h77); wr(3, 1); wr(3, 0);
      wr(0, 0);
      wr(4, 0); wr(6, 0); wr(8, 1);
      wr(0, 6); wr(1, 1); wr(1, 0);
      sen(); check("R3 pointer restarted at 0", int'(pat_out), 'h77);
      sen(); check("R5 word 1", int'(pat_out), wv(1));
      sen(); check("R5 word 2", int'(pat_out), wv(2));
      check("R6 single pass done", int'(busy), 0);

      // R7: endless loop, then halt
      wr(8, 0); wr(4, 2); wr(6, 5);
      wr(1, 1); wr(1, 0);
      repeat (20) sen();
      check("R7 endless still busy", int'(busy), 1);
      wr(0, 0);
      check("R7 busy one cycle after write", int'(busy), 1);
      @(negedge clk);
      check("R7 halted", int'(busy), 0);

      // R10: window clipped at 1022, saturated step data at the top
      wr(4, 'hFC); wr(5, 3); wr(6, 'hFD); wr(7, 3); wr(8, 1);
      wr(0, 6); wr(1, 1); wr(1, 0);
      sen(); check("R10 first address 1020", int'(pat_out), wv(1020));
      sen(); check("R10 address 1021", int'(pat_out), wv(1021));
      sen(); check("R3 saturated top word", int'(pat_out), 'h5A);
      check("R10 clipped end", int'(busy), 0);

      repeat (3) @(negedge clk);
      summary();
      $finish;
   end
endmodule